// File: doc/BRIEF.md
# Write Status Readback Logic

This block forms the read side of a byte-wide nonvolatile memory. A read access is open while both active-low selects, `ce_n` and `oe_n`, are low. Outside a program cycle the block passes the array word to the data bus. While the write controller reports an internal program cycle through `busy`, the block puts a status byte on the bus instead. Software can then see that a write has finished without waiting the worst-case program time.

The status byte carries two indicators. The top bit (bit 7) is a complement poll: for a read of the address that was written last, it returns the inverse of that byte's top bit; for any other address it returns 0. Bit 6 is a toggle indicator: it changes value after every completed read access during the program cycle. Bits 5 to 0 are reserved and read as 0. When `busy` falls, the toggle stops, and reads return stored array data again, including the true top bit.

A small state machine tracks two things: whether an access is open and whether a program cycle is running. Its states are `ST_IDLE`, `ST_READ`, `ST_PGM_IDLE` and `ST_PGM_READ`. Its transitions are:
- start_access: enters a READ state when the select is sampled active.
- end_access: leaves a READ state when the select is sampled inactive.
- begin_program: moves from a non-program state to a program state.
- end_program: moves from a program state to a non-program state.

The toggle register is cleared on begin_program. It is inverted on end_access out of `ST_PGM_READ` while `busy` is still high.

Top module: `eeprom_status_rd`

## Requirements
- R1: `rd_oe` is 1 exactly while `ce_n` and `oe_n` are both 0. While `rd_oe` is 0, `rd_data` is 0.
- R2: While `busy` is 0 and `rd_oe` is 1, `rd_data` equals `array_data`. After a program cycle ends, bit 7 therefore shows true stored data.
- R3: While `busy` is 1, a read of `addr == last_addr` returns the inverse of `last_msb` on bit 7.
- R4: While `busy` is 1, a read of any other address returns 0 on bit 7.
- R5: While `busy` is 1, bits 5 to 0 of `rd_data` read as 0.
- R6: While `busy` is 1, the value returned on bit 6 inverts after each read access. An access is counted at the first clock edge that samples the select inactive after it was sampled active.
- R7: At the first clock edge that samples `busy` high after it was low, the toggle value is set to 0. The first read of a program cycle therefore returns 0 on bit 6.
- R8: A select pulse that is not sampled active at any clock edge does not count as an access and does not advance bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output select |
| addr | input | AW (16) | Read address |
| busy | input | 1 | Internal program cycle in progress |
| last_addr | input | AW (16) | Address of the last byte written |
| last_msb | input | 1 | Top bit of the last byte written |
| array_data | input | DW (8) | Word read from the array at `addr` |
| rd_data | output | DW (8) | Data for the bus driver |
| rd_oe | output | 1 | Enable for the tristate bus driver |

## Verification
The bench sweeps every array value with the program cycle off and all four select combinations in both modes. A mux that leaked status into normal reads, or drove the bus with one select still high, would show up there.

During a program cycle it alternates reads of the last address and of other addresses while flipping the written top bit. A design that returned the true bit or polled every address would fail those reads.

It also ends one program cycle with the toggle at 1 and starts another, so a toggle that is never cleared would return 1 on the first new read. It issues a select pulse that falls between clock edges; a design that counted it would be out of step on bit 6 afterwards.

// File: rtl/eeprom_status_pkg.sv
package eeprom_status_pkg;
    // bit 1: program cycle running, bit 0: read access open
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_READ     = 2'b01,
        ST_PGM_IDLE = 2'b10,
        ST_PGM_READ = 2'b11
    } rd_state_t;
endpackage

// File: rtl/eeprom_status_seq.sv
module eeprom_status_seq
    import eeprom_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      busy,
    output rd_state_t state,
    output logic      toggle
);
    rd_state_t state_nxt;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (busy)     state_nxt = sel ? ST_PGM_READ : ST_PGM_IDLE; // begin_program
                else if (sel) state_nxt = ST_READ;                         // start_access
            end
            ST_READ: begin
                if (busy)      state_nxt = sel ? ST_PGM_READ : ST_PGM_IDLE; // begin_program
                else if (!sel) state_nxt = ST_IDLE;                         // end_access
            end
            ST_PGM_IDLE: begin
                if (!busy)    state_nxt = sel ? ST_READ : ST_IDLE;          // end_program
                else if (sel) state_nxt = ST_PGM_READ;                      // start_access
            end
            ST_PGM_READ: begin
                if (!busy)     state_nxt = sel ? ST_READ : ST_IDLE;         // end_program
                else if (!sel) state_nxt = ST_PGM_IDLE;                     // end_access
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // toggle register, updated on named transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_READ: begin
                    if (busy) toggle <= 1'b0;            // begin_program
                end
                ST_PGM_READ: begin
                    if (busy && !sel) toggle <= ~toggle; // counted end_access
                end
                ST_PGM_IDLE: ;
                default: toggle <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_status_mux.sv
module eeprom_status_mux #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          rd_en,
    input  logic          busy,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] last_addr,
    input  logic          last_msb,
    input  logic [DW-1:0] array_data,
    input  logic          toggle,
    output logic [DW-1:0] rd_data
);
    localparam int POLL_BIT = DW - 1;
    localparam int TGL_BIT  = DW - 2;

    logic hit;
    assign hit = (addr == last_addr);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign rd_data[i] = rd_en & (busy ? (hit & ~last_msb) : array_data[i]);
        end else if (i == TGL_BIT) begin : g_tgl
            assign rd_data[i] = rd_en & (busy ? toggle : array_data[i]);
        end else begin : g_rsvd
            assign rd_data[i] = rd_en & ~busy & array_data[i];
        end
    end
endmodule

// File: rtl/eeprom_status_rd.sv
module eeprom_status_rd
    import eeprom_status_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    input  logic [AW-1:0] last_addr,
    input  logic          last_msb,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe
);
    logic      sel;
    rd_state_t state;
    logic      toggle;

    assign sel   = ~ce_n & ~oe_n;
    assign rd_oe = sel;

    eeprom_status_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .busy   (busy),
        .state  (state),
        .toggle (toggle)
    );

    eeprom_status_mux #(.AW(AW), .DW(DW)) u_mux (
        .rd_en      (sel),
        .busy       (busy),
        .addr       (addr),
        .last_addr  (last_addr),
        .last_msb   (last_msb),
        .array_data (array_data),
        .toggle     (toggle),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/eeprom_status_chk.sv
module eeprom_status_chk
    import eeprom_status_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] last_addr,
    input logic          last_msb,
    input logic [DW-1:0] array_data,
    input logic [DW-1:0] rd_data,
    input logic          rd_oe,
    input logic          sel,
    input rd_state_t     state,
    input logic          toggle
);
    logic in_pgm;
    assign in_pgm = (state == ST_PGM_IDLE) || (state == ST_PGM_READ);

    assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0));

    assert_array_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && !busy) |-> (rd_data == array_data));

    assert_poll_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && busy && addr == last_addr) |-> (rd_data[DW-1] == ~last_msb));

    assert_poll_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && busy && addr != last_addr) |-> (rd_data[DW-1] == 1'b0));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && busy) |-> (rd_data[DW-3:0] == '0));

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_READ && busy && !sel) |=> (toggle != $past(toggle)));

    assert_toggle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_pgm) |=> (toggle == 1'b0));

    assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_IDLE && busy && !sel) |=> $stable(toggle));
endmodule

bind eeprom_status_rd eeprom_status_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .addr       (addr),
    .last_addr  (last_addr),
    .last_msb   (last_msb),
    .array_data (array_data),
    .rd_data    (rd_data),
    .rd_oe      (rd_oe),
    .sel        (sel),
    .state      (state),
    .toggle     (toggle)
);

// File: tb/eeprom_status_rd_tb.sv
module eeprom_status_rd_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic        busy = 1'b0;
    logic [15:0] last_addr = 16'h1234;
    logic        last_msb = 1'b0;
    logic [7:0]  array_data = '0;
    logic [7:0]  rd_data;
    logic        rd_oe;

    int checks = 0;
    int fails  = 0;
    logic exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_status_rd u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .busy(busy), .last_addr(last_addr), .last_msb(last_msb),
        .array_data(array_data), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one read access spanning two clock edges
    task automatic pgm_read(input logic [15:0] a, input string req);
        logic [7:0] exp;
        exp = {(a == last_addr) ? ~last_msb : 1'b0, exp_t, 6'b0};
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(req, rd_data, exp);
        chk("R1", {7'b0, rd_oe}, 8'h01);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        #1;
        chk("R1", {rd_data, rd_oe} == 9'h0 ? 8'h00 : 8'hFF, 8'h00);
        @(posedge clk);
        exp_t = ~exp_t;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset", rd_data, 8'h00);
        chk("R1 reset", {7'b0, rd_oe}, 8'h00);

        // R1: all select combinations, both modes
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                busy = b[0]; ce_n = s[0]; oe_n = s[1];
                addr = 16'h0F00; array_data = 8'hA5;
                #1;
                chk("R1 select", {7'b0, rd_oe}, (s == 0) ? 8'h01 : 8'h00);
                if (s != 0) chk("R1 data", rd_data, 8'h00);
            end
        end
        @(negedge clk);
        busy = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2: exhaustive array sweep outside a program cycle
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        for (int v = 0; v < 256; v++) begin
            array_data = v[7:0];
            addr = (v[0]) ? last_addr : 16'(v * 97);
            #1;
            chk("R2 array", rd_data, v[7:0]);
        end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        array_data = 8'hFF;

        // program cycle 1
        @(negedge clk);
        busy = 1'b1;
        @(posedge clk);
        exp_t = 1'b0;   // R7
        for (int i = 0; i < 9; i++) begin
            last_msb = i[1];
            if (i[0] == 1'b0) pgm_read(last_addr, "R3 R6 R7 hit");
            else              pgm_read(16'(16'h4000 + i), "R4 R5 R6 miss");
        end
        // R8: select pulse entirely between edges
        @(negedge clk);
        #1; ce_n = 1'b0; oe_n = 1'b0;
        #2; ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        pgm_read(16'h7777, "R8 glitch not counted");
        pgm_read(last_addr, "R6 after glitch");

        // end of program: true data back
        @(negedge clk);
        busy = 1'b0; addr = last_addr; array_data = 8'h80;
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R2 after program", rd_data, 8'h80);
        array_data = 8'h40;
        #1;
        chk("R2 after program", rd_data, 8'h40);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;

        // program cycle 2: toggle ended at 1, must restart at 0
        chk("R7 prior toggle", {7'b0, exp_t}, 8'h01);
        @(negedge clk);
        busy = 1'b1;
        @(posedge clk);
        exp_t = 1'b0;
        pgm_read(last_addr, "R7 restart");
        pgm_read(16'h0001, "R6 second cycle");
        @(negedge clk);
        busy = 1'b0;
        repeat (2) @(posedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule